// File: doc/BRIEF.md
# Per-Unit Demand Clock Gating Controller

This block decides, every clock cycle and separately for each execution unit of a processor pipeline, whether that unit's clock runs. A unit gets a clock edge when the dispatch stage is sending it an instruction in the current cycle, or when the unit reports work still in flight. Otherwise its clock is stopped. The unit stays powered, and no state is lost. Each unit's clock passes through a gating cell. The cell holds its enable in a latch that is open only while the clock is low, so the gated clock cannot glitch.

The whole scheme is switched by one bit of a configuration word. That bit is sampled once, on the first rising edge after reset is released. A small mode state machine holds the result until the next reset. The machine has three states. `CG_HOLD` is entered by reset, and in it every clock runs. On the first edge out of reset it takes the transition HOLD→DEMAND when the bit is set, or HOLD→FREE when it is clear. `CG_FREE` keeps every unit clock running. `CG_DEMAND` applies per-unit gating. The only transitions out of FREE and DEMAND go back to HOLD, and only through reset. Because the enables are combinational in the dispatch and busy signals and are latched in the low phase, the gated edge that captures a dispatched instruction is the same edge the ungated clock would have delivered. No issue cycle is lost, and the gating is invisible from the outside.

Top module: `exu_clk_gate_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released (state CG_HOLD), every unit enable is 1.
- R2: Bit GATE_BIT (default 11) of `cfg_word` is sampled only on the first rising edge after reset. If it is 1 the block enters CG_DEMAND, and if it is 0 it enters CG_FREE. Later changes of the bit have no effect until the next reset.
- R3: In CG_FREE every unit enable is 1, whatever the dispatch and busy inputs are.
- R4: In CG_DEMAND, a unit whose bit in `disp_unit_sel` is 1 while `disp_valid` is 1 has its enable at 1 in that same cycle. Its gated clock then pulses on the next rising edge.
- R5: In CG_DEMAND, a unit whose `unit_busy` bit is 1 has its enable at 1 in that cycle.
- R6: In CG_DEMAND, a unit with neither a dispatch nor a busy flag has enable 0, and its gated clock stays low through the next clock period.
- R7: When `disp_valid` is 0, `disp_unit_sel` has no effect on any enable.
- R8: `unit_gclk[i]` is high only during a high phase of `clk` whose preceding low phase ended with enable i at 1. An enable change made while `clk` is high does not reach the gated clock until after the next falling edge.
- R9: Each unit's enable depends only on its own select and busy bits. Several units may be enabled in one cycle, and `disp_unit_sel` is a bit mask, one bit per unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | CFG_W | Configuration word; bit GATE_BIT turns gating on |
| disp_valid | input | 1 | Dispatch stage issues this cycle |
| disp_unit_sel | input | NUM_UNITS | Mask of unit types targeted by the dispatch |
| unit_busy | input | NUM_UNITS | Per-unit flag: instructions still in flight |
| unit_clk_en | output | NUM_UNITS | Latched per-unit clock enable |
| unit_gclk | output | NUM_UNITS | Gated per-unit clock |

## Verification
The enable for a cycle is due at the end of that cycle's low phase. The matching gated pulse is due in the high phase that follows the next rising edge. The mode is due one rising edge after reset is released. The bench changes its inputs 1 ns after each rising edge. It compares `unit_clk_en` with its reference model 8 ns after the edge, and it compares `unit_gclk` 3 ns after the edge with the enable it predicted for the previous cycle. Because the inputs change at 1 ns, inside the high phase, the 3 ns sample also confirms that a change made while the clock is high is held back until the latch opens again.

// File: rtl/exu_cg_pkg.sv
package exu_cg_pkg;
    typedef enum logic [1:0] {
        CG_HOLD   = 2'd0,
        CG_FREE   = 2'd1,
        CG_DEMAND = 2'd2
    } cg_mode_e;
endpackage

// File: rtl/exu_cg_mode_fsm.sv
module exu_cg_mode_fsm
    import exu_cg_pkg::*;
#(
    parameter int CFG_W    = 16,
    parameter int GATE_BIT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    output cg_mode_e         mode,
    output logic             force_all
);
    localparam int SEL_BIT = (GATE_BIT < CFG_W) ? GATE_BIT : CFG_W - 1;

    cg_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CG_HOLD:   state_d = cfg_word[SEL_BIT] ? CG_DEMAND : CG_FREE;
            CG_FREE:   state_d = CG_FREE;
            CG_DEMAND: state_d = CG_DEMAND;
            default:   state_d = CG_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CG_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        mode      = state_q;
        force_all = (state_q != CG_DEMAND);
    end

    // R2: once a mode is chosen it never changes until reset
    a_r2_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != CG_HOLD) |=> $stable(state_q));
    // R2: HOLD lasts exactly one edge after reset
    a_r2_leave_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CG_HOLD) |=> (state_q != CG_HOLD));
endmodule

// File: rtl/exu_cg_demand.sv
module exu_cg_demand #(
    parameter int NUM_UNITS = 4
) (
    input  logic                 force_all,
    input  logic                 disp_valid,
    input  logic [NUM_UNITS-1:0] disp_unit_sel,
    input  logic [NUM_UNITS-1:0] unit_busy,
    output logic [NUM_UNITS-1:0] en_req
);
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        always_comb begin
            en_req[u] = force_all
                      | (disp_valid & disp_unit_sel[u])
                      | unit_busy[u];
        end
    end
endmodule

// File: rtl/exu_cg_cell.sv
module exu_cg_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    output logic en_q_o,
    output logic gclk_o
);
    logic en_lat;

    always_latch begin
        if (!clk_i) en_lat = en_i;
    end

    assign en_q_o = en_lat;
    assign gclk_o = clk_i & en_lat;

    // R8: the held enable does not move during a high phase
    a_r8_latch_closed_high: assert property (@(clk_i) disable iff (!rst_ni)
        clk_i |-> $stable(en_lat));
endmodule

// File: rtl/exu_clk_gate_ctrl.sv
module exu_clk_gate_ctrl
    import exu_cg_pkg::*;
#(
    parameter int NUM_UNITS = 4,
    parameter int CFG_W     = 16,
    parameter int GATE_BIT  = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_word,
    input  logic                 disp_valid,
    input  logic [NUM_UNITS-1:0] disp_unit_sel,
    input  logic [NUM_UNITS-1:0] unit_busy,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic [NUM_UNITS-1:0] unit_gclk
);
    cg_mode_e               mode;
    logic                   force_all;
    logic [NUM_UNITS-1:0]   en_req;

    exu_cg_mode_fsm #(.CFG_W(CFG_W), .GATE_BIT(GATE_BIT)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_word  (cfg_word),
        .mode      (mode),
        .force_all (force_all)
    );

    exu_cg_demand #(.NUM_UNITS(NUM_UNITS)) u_demand (
        .force_all     (force_all),
        .disp_valid    (disp_valid),
        .disp_unit_sel (disp_unit_sel),
        .unit_busy     (unit_busy),
        .en_req        (en_req)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_cell
        exu_cg_cell u_cell (
            .clk_i  (clk),
            .rst_ni (rst_n),
            .en_i   (en_req[u]),
            .en_q_o (unit_clk_en[u]),
            .gclk_o (unit_gclk[u])
        );

        // R4: a dispatched unit holds its enable into the capturing edge
        a_r4_dispatch_on: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_valid && disp_unit_sel[u]) |-> unit_clk_en[u]);
        // R5: in-flight work keeps the clock running
        a_r5_busy_on: assert property (@(posedge clk) disable iff (!rst_n)
            unit_busy[u] |-> unit_clk_en[u]);
        // R6: no demand in gating mode means a stopped clock
        a_r6_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
            (mode == CG_DEMAND && !unit_busy[u] && !(disp_valid && disp_unit_sel[u]))
            |-> !unit_clk_en[u]);
    end

    // R1, R3: outside gating mode every clock runs
    a_r3_free_all_on: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != CG_DEMAND) |-> (&unit_clk_en));
endmodule

// File: tb/tb_exu_clk_gate_ctrl.sv
module tb_exu_clk_gate_ctrl;
    localparam int N  = 4;
    localparam int CW = 16;
    localparam int GB = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_word = '0;
    logic          disp_valid = 1'b0;
    logic [N-1:0]  disp_unit_sel = '0;
    logic [N-1:0]  unit_busy = '0;
    logic [N-1:0]  unit_clk_en;
    logic [N-1:0]  unit_gclk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    exu_clk_gate_ctrl #(.NUM_UNITS(N), .CFG_W(CW), .GATE_BIT(GB)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .disp_valid(disp_valid), .disp_unit_sel(disp_unit_sel),
        .unit_busy(unit_busy), .unit_clk_en(unit_clk_en), .unit_gclk(unit_gclk)
    );

    always #5 clk = ~clk;

    // reference model: 0 hold, 1 free, 2 demand
    int          mdl_mode = 0;
    bit          mdl_sampled_bit = 0;
    logic [N-1:0] prev_exp = '1;

    function automatic string tag_for(int u);
        if (!rst_n || mdl_mode == 0) return "R1";
        if (cfg_word[GB] != mdl_sampled_bit) return "R2";
        if (mdl_mode == 1) return "R3";
        if (disp_valid && $countones(disp_unit_sel) > 1) return "R9";
        if (disp_valid && disp_unit_sel[u]) return "R4";
        if (unit_busy[u]) return "R5";
        if (!disp_valid && disp_unit_sel[u]) return "R7";
        return "R6";
    endfunction

    initial begin
        forever begin
            @(posedge clk);
            if (!rst_n) mdl_mode = 0;
            else if (mdl_mode == 0) begin
                mdl_sampled_bit = cfg_word[GB];
                mdl_mode = cfg_word[GB] ? 2 : 1;
            end
            #3;
            for (int u = 0; u < N; u++) begin
                checks++;
                if (unit_gclk[u] !== prev_exp[u]) begin
                    errors++;
                    $display("FAIL R8 unit %0d gclk actual %b expected %b at %0t",
                             u, unit_gclk[u], prev_exp[u], $time);
                end
            end
            #5;
            for (int u = 0; u < N; u++) begin
                logic e;
                if (!rst_n || mdl_mode != 2) e = 1'b1;
                else e = (disp_valid && disp_unit_sel[u]) || unit_busy[u];
                checks++;
                if (unit_clk_en[u] !== e) begin
                    errors++;
                    $display("FAIL %s unit %0d enable actual %b expected %b at %0t",
                             tag_for(u), u, unit_clk_en[u], e, $time);
                end
                prev_exp[u] = e;
            end
        end
    end

    task automatic step(input logic v, input logic [N-1:0] sel, input logic [N-1:0] busy);
        @(posedge clk);
        #1;
        disp_valid = v;
        disp_unit_sel = sel;
        unit_busy = busy;
    endtask

    task automatic do_reset(input logic gate_bit);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        disp_valid = 1'b0;
        disp_unit_sel = '0;
        unit_busy = '0;
        cfg_word = '0;
        cfg_word[GB] = gate_bit;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        // R1: reset state, gating requested
        cfg_word[GB] = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // first cycle after release is HOLD (R1), then DEMAND
        step(1'b0, '0, '0);            // R6: all idle
        step(1'b1, 4'b0001, '0);       // R4
        step(1'b1, 4'b0100, '0);       // R4 on another unit
        step(1'b0, 4'b1010, '0);       // R7: sel without valid
        step(1'b0, '0, 4'b0010);       // R5
        step(1'b1, 4'b1001, 4'b0100);  // R9: several units together
        step(1'b1, 4'b1111, '0);       // R9: all units
        step(1'b0, '0, '0);            // R6
        cfg_word[GB] = 1'b0;           // R2: ignored now
        step(1'b0, '0, '0);
        step(1'b1, 4'b0010, 4'b1000);
        step(1'b0, '0, '0);
        // walk each unit alone
        for (int u = 0; u < N; u++) begin
            step(1'b1, 4'(1 << u), '0);
            step(1'b0, '0, 4'(1 << u));
            step(1'b0, '0, '0);
        end
        // R2/R3: reset with the bit clear selects FREE
        do_reset(1'b0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);            // R3
        step(1'b1, 4'b0011, '0);
        cfg_word[GB] = 1'b1;           // R2: ignored in FREE
        step(1'b0, 4'b0100, 4'b0001);
        step(1'b0, '0, '0);
        // back to DEMAND through reset
        do_reset(1'b1);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b1, 4'b1000, '0);
        step(1'b0, '0, '0);
        // reset asserted mid-run while idle: R1
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        step(1'b0, '0, '0);
        step(1'b0, '0, 4'b0100);
        step(1'b0, '0, '0);
        repeat (2) @(posedge clk);
        #9;
        finish_run();
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired at %0t", $time);
        finish_run();
    end
endmodule